// File: doc/BRIEF.md
# Programmable Raster Timing and Test-Pattern Generator

This block produces a complete video raster from a pixel clock: a vertical sync, a horizontal sync and a data-enable, each placed by its own programmable delay, high, low and repeat counts measured in pixel clocks. During data-enable it drives a 24-bit pixel taken from one of two built-in sources: a two-colour checkerboard whose squares, and whose line-to-line alternation, are set by small repeat counts, or a gradient that grows by a programmable step on each active pixel.

All timing and pattern fields arrive on a flat configuration port. The block copies that port into a shadow bank whenever a frame begins, so software may rewrite any field at any time and the frame in progress is never torn; the new values appear from the next frame on. A run input starts and stops the raster; stopping is immediate.

Top module: `raster_patgen`

## Requirements
- R1: After reset, vs_o, hs_o and de_o are low and pixel_o is zero.
- R2: cfg_mode selects the source: 1 gives the checkerboard, 2 gives the gradient; 0 and 3 keep the raster stopped even with run high.
- R3: A frame lasts cfg_vs_high + cfg_vs_low pixel clocks; vs_o is high for frame positions p with cfg_vs_dly <= p < cfg_vs_dly + cfg_vs_high, and frames follow each other without a gap.
- R4: hs_o is a train of cfg_hs_num pulses starting at position cfg_vs_dly + cfg_hs_dly, each high for cfg_hs_high clocks and then low for cfg_hs_low clocks.
- R5: de_o is a train of cfg_de_num pulses starting at position cfg_vs_dly + cfg_de_dly, each high for cfg_de_high clocks and then low for cfg_de_low clocks; each pulse is one active line.
- R6: In checkerboard mode pixel_o shows cfg_color_a for cfg_rpt_a pixels, then cfg_color_b for cfg_rpt_b pixels, repeating along the line (a repeat of 0 counts as 1); after every cfg_alt completed active lines the two colours swap roles (cfg_alt of 0 never swaps); the line counter restarts each frame; pixel_o is zero whenever de_o is low. Colours pass unchanged, blue in [23:16], green in [15:8], red in [7:0].
- R7: In gradient mode the n-th pixel of an active line (n from 0) has value g = n * cfg_grad_step modulo 256, and pixel_o carries g in all three bytes.
- R8: While run is low, or the running mode is 0 or 3, all outputs are low/zero; dropping run clears the outputs two clock edges later.
- R9: Configuration is taken only at a frame start; a field written during a frame affects the outputs only from the next frame on.
- R10: A pulse count of zero (cfg_hs_num or cfg_de_num) keeps that signal low for the whole frame.
- R11: Each active line starts afresh: the gradient at 0 and the checkerboard at the first square of the line's current colour phase.
- R12: Frame position 0 appears on the outputs after the second rising clock edge at which run is high, and position p one edge after position p-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Raster run enable |
| cfg_mode | input | 2 | Pattern source select |
| cfg_vs_dly | input | 24 | Clocks from frame start to vertical sync |
| cfg_vs_high | input | 24 | Vertical sync high time |
| cfg_vs_low | input | 24 | Vertical sync low time |
| cfg_hs_dly | input | 24 | Clocks from vertical sync start to first horizontal sync |
| cfg_hs_high | input | 16 | Horizontal sync high time |
| cfg_hs_low | input | 16 | Horizontal sync low time |
| cfg_hs_num | input | 16 | Horizontal sync pulses per frame |
| cfg_de_dly | input | 24 | Clocks from vertical sync start to first active line |
| cfg_de_high | input | 16 | Active pixels per line |
| cfg_de_low | input | 16 | Blanking clocks between active lines |
| cfg_de_num | input | 16 | Active lines per frame |
| cfg_color_a | input | 24 | First checkerboard colour |
| cfg_color_b | input | 24 | Second checkerboard colour |
| cfg_rpt_a | input | 8 | Width of a first-colour square |
| cfg_rpt_b | input | 8 | Width of a second-colour square |
| cfg_alt | input | 8 | Active lines between colour swaps |
| cfg_grad_step | input | 8 | Gradient increment per pixel |
| vs_o | output | 1 | Vertical sync |
| hs_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable |
| pixel_o | output | 24 | Pixel value |

## Verification
Every output is registered once behind the frame-position counter, which itself starts one edge after run rises, so frame position p is due after edge p+2 counted from the edge that first sees run high; the scoreboard therefore starts popping its queue of per-position expectations at the falling edge that follows the second rising edge, and pops one entry per clock from then on. A configuration change written mid-frame is expected to show only from the first position of the following frame, so the expectation queue holds the old values up to that boundary. Dropping run is checked two edges later, and stopped modes are checked over a stretch of clocks while run stays high.

// File: rtl/raster_patgen_pkg.sv
package raster_patgen_pkg;

    parameter int LONG_W  = 24;
    parameter int SHORT_W = 16;
    parameter int BYTE_W  = 8;
    parameter int MODE_W  = 2;

    localparam int COLOR_W    = 3 * BYTE_W;
    localparam int FRM_W      = LONG_W + 1;
    localparam int SYNC_DLY_W = LONG_W + 1;

    typedef enum logic [MODE_W-1:0] {
        PAT_OFF      = 2'd0,
        PAT_CHECKER  = 2'd1,
        PAT_GRADIENT = 2'd2,
        PAT_RSVD     = 2'd3
    } pat_mode_e;

    typedef enum logic [1:0] {
        PH_DONE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_PULSE = 2'd2
    } train_phase_e;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [LONG_W-1:0]  vs_dly;
        logic [LONG_W-1:0]  vs_high;
        logic [LONG_W-1:0]  vs_low;
        logic [LONG_W-1:0]  hs_dly;
        logic [SHORT_W-1:0] hs_high;
        logic [SHORT_W-1:0] hs_low;
        logic [SHORT_W-1:0] hs_num;
        logic [LONG_W-1:0]  de_dly;
        logic [SHORT_W-1:0] de_high;
        logic [SHORT_W-1:0] de_low;
        logic [SHORT_W-1:0] de_num;
        logic [COLOR_W-1:0] color_a;
        logic [COLOR_W-1:0] color_b;
        logic [BYTE_W-1:0]  rpt_a;
        logic [BYTE_W-1:0]  rpt_b;
        logic [BYTE_W-1:0]  alt;
        logic [BYTE_W-1:0]  step;
    } cfg_t;

endpackage

// File: rtl/raster_patgen_train.sv
module raster_patgen_train
    import raster_patgen_pkg::*;
#(
    parameter int DLY_W = 25,
    parameter int LEN_W = 16,
    parameter int NUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             frame_zero,
    input  logic [DLY_W-1:0] dly,
    input  logic [LEN_W-1:0] high,
    input  logic [LEN_W-1:0] low,
    input  logic [NUM_W-1:0] num,
    output logic             pulse
);

    localparam int PER_W = LEN_W + 1;
    localparam int CNT_W = (DLY_W > PER_W) ? DLY_W : PER_W;

    typedef struct packed {
        train_phase_e     phase;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] rep;
    } st_t;

    st_t              st_q, st_d, view;
    logic [PER_W-1:0] period;
    logic             empty;

    always_comb begin
        period = PER_W'(high) + PER_W'(low);
        empty  = (num == '0) || (period == '0);

        // state describing the current frame position
        view = st_q;
        if (frame_zero) begin
            view.cnt = '0;
            view.rep = '0;
            if (empty)
                view.phase = PH_DONE;
            else if (dly == '0)
                view.phase = PH_PULSE;
            else
                view.phase = PH_DELAY;
        end

        pulse = active && (view.phase == PH_PULSE) && (view.cnt < CNT_W'(high));

        st_d = view;
        case (view.phase)
            PH_DELAY: begin
                if (view.cnt == CNT_W'(dly) - CNT_W'(1)) begin
                    st_d.cnt   = '0;
                    st_d.phase = empty ? PH_DONE : PH_PULSE;
                end else begin
                    st_d.cnt = view.cnt + CNT_W'(1);
                end
            end
            PH_PULSE: begin
                if (view.cnt == CNT_W'(period) - CNT_W'(1)) begin
                    st_d.cnt = '0;
                    if (view.rep == num - NUM_W'(1))
                        st_d.phase = PH_DONE;
                    else
                        st_d.rep = view.rep + NUM_W'(1);
                end else begin
                    st_d.cnt = view.cnt + CNT_W'(1);
                end
            end
            default: st_d = view;
        endcase

        if (!active) begin
            st_d.phase = PH_DONE;
            st_d.cnt   = '0;
            st_d.rep   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_DONE;
            st_q.cnt   <= '0;
            st_q.rep   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: inside a pulse period the phase counter stays below the period
    assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && view.phase == PH_PULSE) |-> (view.cnt < CNT_W'(period)));

    // R10: a train with zero pulses never reaches the pulse phase
    assert_zero_count_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && view.phase == PH_PULSE) |-> (num != '0));

endmodule

// File: rtl/raster_patgen_pixel.sv
module raster_patgen_pixel
    import raster_patgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               frame_zero,
    input  logic               de,
    input  logic [MODE_W-1:0]  mode,
    input  logic [COLOR_W-1:0] color_a,
    input  logic [COLOR_W-1:0] color_b,
    input  logic [BYTE_W-1:0]  rpt_a,
    input  logic [BYTE_W-1:0]  rpt_b,
    input  logic [BYTE_W-1:0]  alt,
    input  logic [BYTE_W-1:0]  step,
    output logic [COLOR_W-1:0] pixel
);

    typedef struct packed {
        logic              prev_de;
        logic [BYTE_W-1:0] grad;
        logic [BYTE_W-1:0] sq;
        logic              col;
        logic [BYTE_W-1:0] lines;
        logic              phase;
    } pst_t;

    pst_t              p_q, p_d;
    logic              prev_v, first, line_end, phase_v, col_v, eff;
    logic [BYTE_W-1:0] lines_v, grad_v, sq_v, rpt, rpt1;

    always_comb begin
        prev_v   = frame_zero ? 1'b0 : p_q.prev_de;
        phase_v  = frame_zero ? 1'b0 : p_q.phase;
        lines_v  = frame_zero ? '0   : p_q.lines;
        first    = de && !prev_v;
        line_end = prev_v && !de;
        grad_v   = first ? '0   : p_q.grad;
        sq_v     = first ? '0   : p_q.sq;
        col_v    = first ? 1'b0 : p_q.col;
        eff      = col_v ^ phase_v;
        rpt      = eff ? rpt_b : rpt_a;
        rpt1     = (rpt == '0) ? BYTE_W'(1) : rpt;

        pixel = '0;
        if (de) begin
            if (mode == PAT_CHECKER)
                pixel = eff ? color_b : color_a;
            else if (mode == PAT_GRADIENT)
                pixel = {3{grad_v}};
        end

        p_d.prev_de = de;
        p_d.grad    = grad_v;
        p_d.sq      = sq_v;
        p_d.col     = col_v;
        p_d.lines   = lines_v;
        p_d.phase   = phase_v;
        if (de) begin
            p_d.grad = grad_v + step;
            if (sq_v == rpt1 - BYTE_W'(1)) begin
                p_d.sq  = '0;
                p_d.col = !col_v;
            end else begin
                p_d.sq = sq_v + BYTE_W'(1);
            end
        end
        if (line_end) begin
            if ((alt != '0) && (lines_v + BYTE_W'(1) == alt)) begin
                p_d.lines = '0;
                p_d.phase = !phase_v;
            end else begin
                p_d.lines = lines_v + BYTE_W'(1);
            end
        end
        if (!active)
            p_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            p_q <= '0;
        else
            p_q <= p_d;
    end

    // R6: a checkerboard pixel is always one of the two programmed colours
    assert_checker_colour_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && de && mode == PAT_CHECKER) |-> (pixel == color_a || pixel == color_b));

    // R7: consecutive pixels of one gradient line differ by the step
    assert_gradient_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !frame_zero && de && $past(de) && mode == PAT_GRADIENT)
        |-> (pixel[BYTE_W-1:0] == $past(pixel[BYTE_W-1:0]) + $past(step)));

endmodule

// File: rtl/raster_patgen.sv
module raster_patgen
    import raster_patgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic [LONG_W-1:0]  cfg_vs_dly,
    input  logic [LONG_W-1:0]  cfg_vs_high,
    input  logic [LONG_W-1:0]  cfg_vs_low,
    input  logic [LONG_W-1:0]  cfg_hs_dly,
    input  logic [SHORT_W-1:0] cfg_hs_high,
    input  logic [SHORT_W-1:0] cfg_hs_low,
    input  logic [SHORT_W-1:0] cfg_hs_num,
    input  logic [LONG_W-1:0]  cfg_de_dly,
    input  logic [SHORT_W-1:0] cfg_de_high,
    input  logic [SHORT_W-1:0] cfg_de_low,
    input  logic [SHORT_W-1:0] cfg_de_num,
    input  logic [COLOR_W-1:0] cfg_color_a,
    input  logic [COLOR_W-1:0] cfg_color_b,
    input  logic [BYTE_W-1:0]  cfg_rpt_a,
    input  logic [BYTE_W-1:0]  cfg_rpt_b,
    input  logic [BYTE_W-1:0]  cfg_alt,
    input  logic [BYTE_W-1:0]  cfg_grad_step,
    output logic               vs_o,
    output logic               hs_o,
    output logic               de_o,
    output logic [COLOR_W-1:0] pixel_o
);

    localparam int N_LINE_TRAINS = 2;

    typedef struct packed {
        logic               running;
        logic [FRM_W-1:0]   fc;
        cfg_t               sh;
        logic               vs;
        logic               hs;
        logic               de;
        logic [COLOR_W-1:0] px;
    } top_t;

    top_t               q, d;
    cfg_t               cfg_in;
    logic [FRM_W-1:0]   frame_len;
    logic               frame_last, load, frame_zero;
    logic               vs_w;
    logic [COLOR_W-1:0] px_w;

    logic [SYNC_DLY_W-1:0] tr_dly   [N_LINE_TRAINS];
    logic [SHORT_W-1:0]    tr_high  [N_LINE_TRAINS];
    logic [SHORT_W-1:0]    tr_low   [N_LINE_TRAINS];
    logic [SHORT_W-1:0]    tr_num   [N_LINE_TRAINS];
    logic [N_LINE_TRAINS-1:0] tr_pulse;

    function automatic logic mode_ok(input logic [MODE_W-1:0] m);
        return (m == PAT_CHECKER) || (m == PAT_GRADIENT);
    endfunction

    always_comb begin
        cfg_in.mode    = cfg_mode;
        cfg_in.vs_dly  = cfg_vs_dly;
        cfg_in.vs_high = cfg_vs_high;
        cfg_in.vs_low  = cfg_vs_low;
        cfg_in.hs_dly  = cfg_hs_dly;
        cfg_in.hs_high = cfg_hs_high;
        cfg_in.hs_low  = cfg_hs_low;
        cfg_in.hs_num  = cfg_hs_num;
        cfg_in.de_dly  = cfg_de_dly;
        cfg_in.de_high = cfg_de_high;
        cfg_in.de_low  = cfg_de_low;
        cfg_in.de_num  = cfg_de_num;
        cfg_in.color_a = cfg_color_a;
        cfg_in.color_b = cfg_color_b;
        cfg_in.rpt_a   = cfg_rpt_a;
        cfg_in.rpt_b   = cfg_rpt_b;
        cfg_in.alt     = cfg_alt;
        cfg_in.step    = cfg_grad_step;
    end

    // HS and DE trains are placed relative to the vertical sync start
    assign tr_dly[0]  = SYNC_DLY_W'(q.sh.vs_dly) + SYNC_DLY_W'(q.sh.hs_dly);
    assign tr_high[0] = q.sh.hs_high;
    assign tr_low[0]  = q.sh.hs_low;
    assign tr_num[0]  = q.sh.hs_num;
    assign tr_dly[1]  = SYNC_DLY_W'(q.sh.vs_dly) + SYNC_DLY_W'(q.sh.de_dly);
    assign tr_high[1] = q.sh.de_high;
    assign tr_low[1]  = q.sh.de_low;
    assign tr_num[1]  = q.sh.de_num;

    raster_patgen_train #(
        .DLY_W (LONG_W),
        .LEN_W (LONG_W),
        .NUM_W (1)
    ) i_vs_train (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (q.running),
        .frame_zero (frame_zero),
        .dly        (q.sh.vs_dly),
        .high       (q.sh.vs_high),
        .low        (q.sh.vs_low),
        .num        (1'b1),
        .pulse      (vs_w)
    );

    for (genvar g = 0; g < N_LINE_TRAINS; g++) begin : g_line_train
        raster_patgen_train #(
            .DLY_W (SYNC_DLY_W),
            .LEN_W (SHORT_W),
            .NUM_W (SHORT_W)
        ) i_train (
            .clk        (clk),
            .rst_n      (rst_n),
            .active     (q.running),
            .frame_zero (frame_zero),
            .dly        (tr_dly[g]),
            .high       (tr_high[g]),
            .low        (tr_low[g]),
            .num        (tr_num[g]),
            .pulse      (tr_pulse[g])
        );
    end

    raster_patgen_pixel i_pixel (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (q.running),
        .frame_zero (frame_zero),
        .de         (tr_pulse[1]),
        .mode       (q.sh.mode),
        .color_a    (q.sh.color_a),
        .color_b    (q.sh.color_b),
        .rpt_a      (q.sh.rpt_a),
        .rpt_b      (q.sh.rpt_b),
        .alt        (q.sh.alt),
        .step       (q.sh.step),
        .pixel      (px_w)
    );

    always_comb begin
        frame_len  = FRM_W'(q.sh.vs_high) + FRM_W'(q.sh.vs_low);
        frame_last = (frame_len == '0) || (q.fc == frame_len - FRM_W'(1));
        load       = !q.running || frame_last;
        frame_zero = q.running && (q.fc == '0);

        d.sh      = load ? cfg_in : q.sh;
        d.running = run && (load ? mode_ok(cfg_in.mode) : mode_ok(q.sh.mode));
        d.fc      = (!d.running || load) ? '0 : q.fc + FRM_W'(1);
        d.vs      = q.running && vs_w;
        d.hs      = q.running && tr_pulse[0];
        d.de      = q.running && tr_pulse[1];
        d.px      = q.running ? px_w : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign vs_o    = q.vs;
    assign hs_o    = q.hs;
    assign de_o    = q.de;
    assign pixel_o = q.px;

    // R8: a stopped raster drives nothing on the next edge
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.running |=> (!vs_o && !hs_o && !de_o && pixel_o == '0));

    // R6: the pixel bus is zero outside data-enable
    assert_pixel_outside_de_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> (pixel_o == '0));

    // R2: a raster with a stopped mode in its shadow never runs
    assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.running |-> (q.sh.mode == PAT_CHECKER || q.sh.mode == PAT_GRADIENT));

endmodule

// File: tb/test_raster_patgen.sv
module test_raster_patgen;

    typedef struct {
        int mode;
        int vd, vh, vl;
        int hd, hh, hl, hn;
        int dd, dh, dl, dn;
        int ca, cb, ra, rb, alt, step;
    } tcfg_t;

    typedef struct {
        bit    vs, hs, de;
        int    px;
        int    pos;
        string note;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  c_mode;
    logic [23:0] c_vs_dly, c_vs_high, c_vs_low, c_hs_dly, c_de_dly;
    logic [15:0] c_hs_high, c_hs_low, c_hs_num, c_de_high, c_de_low, c_de_num;
    logic [23:0] c_color_a, c_color_b;
    logic [7:0]  c_rpt_a, c_rpt_b, c_alt, c_step;
    logic        vs_o, hs_o, de_o;
    logic [23:0] pixel_o;

    int   checks = 0;
    int   failures = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    raster_patgen i_raster_patgen (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cfg_mode(c_mode), .cfg_vs_dly(c_vs_dly), .cfg_vs_high(c_vs_high),
        .cfg_vs_low(c_vs_low), .cfg_hs_dly(c_hs_dly), .cfg_hs_high(c_hs_high),
        .cfg_hs_low(c_hs_low), .cfg_hs_num(c_hs_num), .cfg_de_dly(c_de_dly),
        .cfg_de_high(c_de_high), .cfg_de_low(c_de_low), .cfg_de_num(c_de_num),
        .cfg_color_a(c_color_a), .cfg_color_b(c_color_b), .cfg_rpt_a(c_rpt_a),
        .cfg_rpt_b(c_rpt_b), .cfg_alt(c_alt), .cfg_grad_step(c_step),
        .vs_o(vs_o), .hs_o(hs_o), .de_o(de_o), .pixel_o(pixel_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic bit train(longint t, longint d, longint h, longint l, longint n);
        longint k, p;
        if (t < d) return 1'b0;
        k = t - d;
        p = h + l;
        if (p == 0 || n == 0) return 1'b0;
        if (k >= n * p) return 1'b0;
        return (k % p) < h;
    endfunction

    function automatic exp_t model(tcfg_t c, longint t);
        exp_t   e;
        longint k, p, r, col, m, ra, rb;
        bit     ph, first, use_a;
        e.vs = (t >= c.vd) && (t < c.vd + c.vh);
        e.hs = train(t, c.vd + c.hd, c.hh, c.hl, c.hn);
        e.de = train(t, c.vd + c.dd, c.dh, c.dl, c.dn);
        e.px = 0;
        e.pos = int'(t);
        if (e.de) begin
            k   = t - (c.vd + c.dd);
            p   = c.dh + c.dl;
            r   = k / p;
            col = k % p;
            if (c.mode == 2) begin
                e.px = int'(((col * c.step) % 256) * 65793);
            end else begin
                ra = (c.ra == 0) ? 1 : c.ra;
                rb = (c.rb == 0) ? 1 : c.rb;
                ph = (c.alt == 0) ? 1'b0 : bit'((r / c.alt) % 2);
                m  = col % (ra + rb);
                first = ph ? (m < rb) : (m < ra);
                use_a = ph ? !first : first;
                e.px = use_a ? c.ca : c.cb;
            end
        end
        return e;
    endfunction

    task automatic push_frame(tcfg_t c, string note);
        longint f;
        exp_t   e;
        f = c.vh + c.vl;
        for (longint t = 0; t < f; t++) begin
            e = model(c, t);
            e.note = note;
            q.push_back(e);
        end
    endtask

    task automatic apply(tcfg_t c);
        c_mode    = 2'(c.mode);
        c_vs_dly  = 24'(c.vd);  c_vs_high = 24'(c.vh); c_vs_low = 24'(c.vl);
        c_hs_dly  = 24'(c.hd);  c_hs_high = 16'(c.hh); c_hs_low = 16'(c.hl);
        c_hs_num  = 16'(c.hn);
        c_de_dly  = 24'(c.dd);  c_de_high = 16'(c.dh); c_de_low = 16'(c.dl);
        c_de_num  = 16'(c.dn);
        c_color_a = 24'(c.ca);  c_color_b = 24'(c.cb);
        c_rpt_a   = 8'(c.ra);   c_rpt_b   = 8'(c.rb);
        c_alt     = 8'(c.alt);  c_step    = 8'(c.step);
    endtask

    task automatic check_quiet(input string tag);
        check(vs_o == 1'b0, {tag, " vs"}, int'(vs_o), 0);
        check(hs_o == 1'b0, {tag, " hs"}, int'(hs_o), 0);
        check(de_o == 1'b0, {tag, " de"}, int'(de_o), 0);
        check(pixel_o == 24'h0, {tag, " pixel"}, int'(pixel_o), 0);
    endtask

    // run the queued frames; optionally rewrite the config mid-way (R9)
    task automatic run_seq(tcfg_t first, bit change, tcfg_t second, int change_at);
        apply(first);
        @(posedge clk); #2 run = 1'b1;
        @(posedge clk);
        @(posedge clk); #2 mon_on = 1'b1;
        if (change) begin
            repeat (change_at) @(posedge clk);
            #2 apply(second);
        end
        while (q.size() > 0) @(posedge clk);
        #2 run = 1'b0;
        mon_on = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_quiet("R8 after run low");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(vs_o == e.vs, $sformatf("R3 %s vs pos=%0d", e.note, e.pos), int'(vs_o), int'(e.vs));
            check(hs_o == e.hs, $sformatf("R4 %s hs pos=%0d", e.note, e.pos), int'(hs_o), int'(e.hs));
            check(de_o == e.de, $sformatf("R5 %s de pos=%0d", e.note, e.pos), int'(de_o), int'(e.de));
            check(int'(pixel_o) == e.px, $sformatf("R6 R7 %s pixel pos=%0d", e.note, e.pos),
                  int'(pixel_o), e.px);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tcfg_t c_main, c_grad, c_sup, c_tiny;

        // reference raster: 8x4 active, porches 88/44/148 and 4/5/36
        c_main = '{mode:1, vd:0, vh:5*288, vl:44*288,
                   hd:0, hh:44, hl:244, hn:49,
                   dd:288*41 + 192, dh:8, dl:280, dn:4,
                   ca:'hfecc00, cb:'h006aa7, ra:3, rb:2, alt:2, step:16};
        c_grad = c_main;
        c_grad.mode = 2; c_grad.step = 5; c_grad.ra = 7; c_grad.alt = 1;

        c_sup = '{mode:2, vd:2, vh:3, vl:37,
                  hd:1, hh:2, hl:3, hn:0,
                  dd:5, dh:4, dl:3, dn:0,
                  ca:'h112233, cb:'h445566, ra:1, rb:1, alt:0, step:9};

        c_tiny = '{mode:1, vd:1, vh:4, vl:60,
                   hd:2, hh:2, hl:5, hn:8,
                   dd:3, dh:6, dl:2, dn:5,
                   ca:'h0000ff, cb:'hff0000, ra:0, rb:2, alt:1, step:0};

        apply(c_main);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 reset");

        // R12/R3-R6: checker frame, then a mid-frame write to gradient (R9, R7, R11)
        push_frame(c_main, "R12 checker");
        push_frame(c_grad, "R9 gradient next frame");
        run_seq(c_main, 1'b1, c_grad, 7000);

        // R10: zero pulse counts suppress HS and DE
        push_frame(c_sup, "R10 zero counts");
        run_seq(c_sup, 1'b0, c_sup, 0);

        // R11/R6: repeat 0 counted as 1, swap each line, two frames restart phase
        push_frame(c_tiny, "R11 line restart");
        push_frame(c_tiny, "R11 frame restart");
        run_seq(c_tiny, 1'b0, c_tiny, 0);

        // R2: modes 0 and 3 keep the raster stopped
        c_tiny.mode = 3;
        apply(c_tiny);
        @(posedge clk); #2 run = 1'b1;
        repeat (10) begin
            @(negedge clk);
            check_quiet("R2 mode 3");
        end
        c_tiny.mode = 0;
        #2 apply(c_tiny);
        repeat (10) begin
            @(negedge clk);
            check_quiet("R2 mode 0");
        end
        @(posedge clk); #2 run = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule